// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit side of an Ethernet MAC that fetches its work from memory. Software keeps a circular chain of 32-byte descriptors. Each descriptor carries an ownership flag, a frame length, a buffer pointer and a pointer to the next descriptor. Software sets the chain's start address through two 16-bit register halves, rewinds the engine with a control bit and then writes a poll command. From then on the engine works without further help. It reads the current descriptor and checks who owns it. For each descriptor it owns, it reads the buffer one 32-bit word at a time, streams the bytes on a byte-wide valid/ready interface and writes the status halfword back with ownership returned to software. It then follows the next pointer and repeats.

The engine stops at the first descriptor that software owns. If a poll arrives while the engine is busy, the engine remembers it and re-reads a non-owned descriptor once before it stops. Each completed descriptor raises a write-one-to-clear interrupt flag, and that flag is gated by an enable bit onto a single interrupt line. A descriptor whose length is zero or above the frame limit is not transmitted. It is handed back with an error flag instead.

Top module: `tx_desc_ring_engine`

## Requirements
- R1: After reset, mem_req, tx_valid and irq are low, and every register reads as zero.
- R2: The ring start address is written as a low 16-bit half (register 2) and a high half (register 3), and both halves read back. Writing 1 to bit 0 of the control register (register 0) loads the current descriptor pointer from that start address.
- R3: Writing 1 to bit 0 of the poll register (register 1) makes the engine read the 32-bit word at the current descriptor. If status bit 15 of that word is clear, the engine reads no buffer, sends no byte, writes nothing back and goes idle.
- R4: The descriptor word at offset 0 holds the status in bits 15:0 and the length in bits 31:16. Offset 4 holds the word-aligned buffer address and offset 8 the next-descriptor address. Exactly length bytes are sent from the buffer, lowest byte address first, and tx_last is high on the final byte only.
- R5: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R6: After the last byte, the engine writes one halfword to offset 0 of the descriptor. In that halfword bit 15 is clear, bit 14 is clear and bits 13:0 are unchanged. The engine then moves to the next pointer and checks that descriptor without a new poll, so the last descriptor links back to the first.
- R7: A descriptor whose length is 0 or greater than 1536 sends no byte. It is written back with bit 15 clear and bit 14 set, and the engine continues to the next descriptor.
- R8: Each written-back descriptor sets interrupt status bit 4 (register 4). Writing 1 to that bit clears it. irq is the OR of the status bits ANDed with the enable bits (register 5, bit 4).
- R9: A memory request keeps its address, direction and data until the cycle in which mem_ack is high.
- R10: The control reset bit aborts any fetch or frame in progress. From the next cycle mem_req and tx_valid are low and no writeback takes place, and the next poll starts again at the ring start address.
- R11: A poll written while the engine is busy is remembered. When the engine then meets a non-owned descriptor, it reads that descriptor once more before it goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a status halfword write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 16 | Status halfword for writeback |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The engine is tried on a single non-owned descriptor, which separates a clean stop from a false start. It is also tried on a two-frame chain with odd lengths, which shows whether byte order, partial final words and tx_last are correct under irregular backpressure. A later poll that wraps from the last descriptor back to the first shows whether the engine really follows the next pointer rather than an index. Two bad lengths confirm that error writeback happens without streaming. A second poll sent during a frame, compared with the earlier single poll, separates the remembered poll from normal stopping. An abort in the middle of a frame, followed by a fresh poll, shows that no writeback happens and that the pointer returns to the ring start.

// File: rtl/tde_pkg.sv
package tde_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_BPTR,
        ST_NPTR,
        ST_WORD,
        ST_SEND,
        ST_WBK
    } walk_st_t;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] stat;
    } desc_hdr_t;

    localparam int OWN_BIT  = 15;
    localparam int ERR_BIT  = 14;
    localparam int DONE_BIT = 4;

    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_POLL    = 3'd1;
    localparam logic [2:0] RA_BASE_LO = 3'd2;
    localparam logic [2:0] RA_BASE_HI = 3'd3;
    localparam logic [2:0] RA_ISR     = 3'd4;
    localparam logic [2:0] RA_IER     = 3'd5;

    function automatic logic len_bad(input logic [15:0] len, input int unsigned max_len);
        return (len == 16'd0) || (32'(len) > max_len);
    endfunction

    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[lane*8 +: 8];
    endfunction

endpackage

// File: rtl/tde_regs.sv
module tde_regs
    import tde_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [15:0]       wdata,
    input  logic              done,
    output logic [15:0]       rdata,
    output logic [ADDR_W-1:0] base,
    output logic              poll,
    output logic              abort,
    output logic              isr_flag,
    output logic              irq
);
    localparam int HI_W = ADDR_W - 16;

    logic [15:0]     base_lo;
    logic [HI_W-1:0] base_hi;
    logic            ier_flag;
    logic [15:0]     isr_vec;
    logic [15:0]     ier_vec;

    assign poll  = we && (addr == RA_POLL) && wdata[0];
    assign abort = we && (addr == RA_CTRL) && wdata[0];
    assign base  = {base_hi, base_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo  <= '0;
            base_hi  <= '0;
            isr_flag <= 1'b0;
            ier_flag <= 1'b0;
        end else begin
            if (we && addr == RA_BASE_LO) base_lo <= wdata;
            if (we && addr == RA_BASE_HI) base_hi <= wdata[HI_W-1:0];
            if (we && addr == RA_IER)     ier_flag <= wdata[DONE_BIT];
            if (done)
                isr_flag <= 1'b1;
            else if (we && addr == RA_ISR && wdata[DONE_BIT])
                isr_flag <= 1'b0;
        end
    end

    always_comb begin
        isr_vec = '0;
        ier_vec = '0;
        isr_vec[DONE_BIT] = isr_flag;
        ier_vec[DONE_BIT] = ier_flag;
    end

    assign irq = |(isr_vec & ier_vec);

    always_comb begin
        case (addr)
            RA_BASE_LO: rdata = base_lo;
            RA_BASE_HI: rdata = 16'(base_hi);
            RA_ISR:     rdata = isr_vec;
            RA_IER:     rdata = ier_vec;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/tde_walker.sv
module tde_walker
    import tde_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MAX_LEN = 1536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll,
    input  logic              abort,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              done
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    walk_st_t          st;
    desc_hdr_t         hdr;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] nptr;
    logic [ADDR_W-3:0] bword;
    logic [31:0]       word;
    logic [1:0]        lane;
    logic [LEN_W-1:0]  remain;
    logic              pend;
    logic              xfer;
    logic              bad;

    assign xfer = mem_req && mem_ack;
    assign bad  = len_bad(hdr.len, MAX_LEN);
    assign done = (st == ST_WBK) && xfer && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            hdr    <= '0;
            cur    <= '0;
            nptr   <= '0;
            bword  <= '0;
            word   <= '0;
            lane   <= '0;
            remain <= '0;
            pend   <= 1'b0;
        end else if (abort) begin
            st   <= ST_IDLE;
            cur  <= base;
            pend <= 1'b0;
        end else begin
            if (poll && st != ST_IDLE) pend <= 1'b1;
            case (st)
                ST_IDLE: if (poll) st <= ST_HDR;
                ST_HDR: if (xfer) begin
                    hdr <= desc_hdr_t'(mem_rdata);
                    if (mem_rdata[OWN_BIT])
                        st <= ST_BPTR;
                    else if (pend || poll)
                        pend <= 1'b0;
                    else
                        st <= ST_IDLE;
                end
                ST_BPTR: if (xfer) begin
                    bword <= mem_rdata[ADDR_W-1:2];
                    st    <= ST_NPTR;
                end
                ST_NPTR: if (xfer) begin
                    nptr <= mem_rdata[ADDR_W-1:0];
                    if (bad) begin
                        st <= ST_WBK;
                    end else begin
                        remain <= hdr.len[LEN_W-1:0];
                        st     <= ST_WORD;
                    end
                end
                ST_WORD: if (xfer) begin
                    word <= mem_rdata;
                    lane <= '0;
                    st   <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    if (remain == LEN_W'(1)) begin
                        st <= ST_WBK;
                    end else begin
                        remain <= remain - LEN_W'(1);
                        if (lane == 2'd3) begin
                            bword <= bword + 1'b1;
                            st    <= ST_WORD;
                        end else begin
                            lane <= lane + 2'd1;
                        end
                    end
                end
                ST_WBK: if (xfer) begin
                    cur <= nptr;
                    st  <= ST_HDR;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_HDR:  begin mem_req = 1'b1; mem_addr = cur; end
            ST_BPTR: begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(4); end
            ST_NPTR: begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(8); end
            ST_WORD: begin mem_req = 1'b1; mem_addr = {bword, 2'b00}; end
            ST_WBK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = {1'b0, bad, hdr.stat[13:0]};
            end
            default: ;
        endcase
    end

    assign tx_valid = (st == ST_SEND);
    assign tx_data  = tx_valid ? lane_byte(word, lane) : 8'h00;
    assign tx_last  = tx_valid && (remain == LEN_W'(1));

endmodule

// File: rtl/tx_desc_ring_engine.sv
module tx_desc_ring_engine
    import tde_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MAX_LEN = 1536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq
);
    logic [ADDR_W-1:0] ring_base;
    logic              poll_p;
    logic              abort_p;
    logic              done_p;
    logic              isr_flag;

    tde_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .done     (done_p),
        .rdata    (reg_rdata),
        .base     (ring_base),
        .poll     (poll_p),
        .abort    (abort_p),
        .isr_flag (isr_flag),
        .irq      (irq)
    );

    tde_walker #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .poll      (poll_p),
        .abort     (abort_p),
        .base      (ring_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .done      (done_p)
    );

endmodule

// File: rtl/tde_checker.sv
module tde_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              abort,
    input logic              done,
    input logic              isr_flag,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst || abort)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst || abort)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_wb_release_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[15]);

    assert_last_then_wb_R6: assert property (@(posedge clk) disable iff (rst || abort)
        tx_valid && tx_ready && tx_last |=> mem_req && mem_we);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !mem_req && !tx_valid);

    assert_done_flag_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> isr_flag);

endmodule

bind tx_desc_ring_engine tde_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort_p),
    .done      (done_p),
    .isr_flag  (isr_flag),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last)
);

// File: tb/sim_tx_desc_ring_engine.sv
`timescale 1ns/1ps
module sim_tx_desc_ring_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #2.5 clk = ~clk;

    tx_desc_ring_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    int rx_count = 0;
    logic [8:0] expq[$];

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // memory model: one wait cycle per access
    logic [31:0] mem [0:255];
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    int          watch_cnt = 0;
    int          wr_cnt = 0;
    int          hold_viol = 0;
    logic        prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        ready_en = 1'b1;
    logic [1:0]  rdy_cnt = '0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            prev_pend <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[9:2]];
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[9:2]][15:0] <= mem_wdata;
                    wr_cnt++;
                end else if (mem_addr == watch_addr) begin
                    watch_cnt++;
                end
            end
            if (prev_pend && mem_req && mem_addr != prev_addr) hold_viol++;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end
        rdy_cnt  <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
        tx_ready <= ready_en && (rdy_cnt != 2'd2);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            rx_count++;
            if (expq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4: unexpected byte actual=0x%0h expected=none", tx_data);
            end else begin
                check_eq("R4/R5 byte {last,data}", {23'd0, tx_last, tx_data}, {23'd0, expq.pop_front()});
            end
        end
    end

    task automatic reg_wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_desc(int a, logic [15:0] st, logic [15:0] len, logic [31:0] b, logic [31:0] n);
        mem[a >> 2]       = {len, st};
        mem[(a >> 2) + 1] = b;
        mem[(a >> 2) + 2] = n;
    endtask

    task automatic fill_buf(int a, int n, int seed);
        for (int k = 0; k < (n + 3) / 4; k++)
            mem[(a >> 2) + k] = {8'(seed + 4*k*7 + 21), 8'(seed + 4*k*7 + 14),
                                 8'(seed + 4*k*7 + 7), 8'(seed + 4*k*7)};
    endtask

    task automatic expect_frame(int a, int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = mem[(a >> 2) + k / 4];
            expq.push_back({k == n - 1, w[(k % 4) * 8 +: 8]});
        end
    endtask

    task automatic wait_quiet();
        int q = 0;
        int g = 0;
        while (q < 16 && g < 20000) begin
            @(negedge clk);
            g++;
            if (!mem_req && !tx_valid) q++; else q = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int base_rx;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        check_eq("R1 mem_req in reset", {31'd0, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 mem_req", {31'd0, mem_req}, 0);
        check_eq("R1 tx_valid", {31'd0, tx_valid}, 0);
        check_eq("R1 irq", {31'd0, irq}, 0);
        reg_rd(3'd2, rd); check_eq("R1 base lo", {16'd0, rd}, 0);
        reg_rd(3'd4, rd); check_eq("R1 isr", {16'd0, rd}, 0);

        // R2: base halves, then rewind
        reg_wr(3'd2, 16'h0100);
        reg_wr(3'd3, 16'h0000);
        reg_rd(3'd2, rd); check_eq("R2 base lo readback", {16'd0, rd}, 32'h0100);
        reg_rd(3'd3, rd); check_eq("R2 base hi readback", {16'd0, rd}, 0);
        reg_wr(3'd0, 16'h0001);

        // R3: not-owned descriptor at start
        set_desc(32'h100, 16'h0000, 16'd4, 32'h200, 32'h120);
        watch_addr = 32'h100; watch_cnt = 0; wr_cnt = 0;
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R2/R3 one header read at ring start", watch_cnt, 1);
        check_eq("R3 no writeback", wr_cnt, 0);
        check_eq("R3 no bytes", rx_count, 0);

        // R4/R5/R6: two frames, stop at third
        set_desc(32'h100, 16'h8123, 16'd5, 32'h200, 32'h120);
        set_desc(32'h120, 16'h8ABC, 16'd9, 32'h240, 32'h140);
        set_desc(32'h140, 16'h0055, 16'd4, 32'h280, 32'h100);
        fill_buf(32'h200, 5, 3);
        fill_buf(32'h240, 9, 90);
        fill_buf(32'h280, 4, 200);
        expect_frame(32'h200, 5);
        expect_frame(32'h240, 9);
        watch_addr = 32'h140; watch_cnt = 0; wr_cnt = 0;
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R4 all bytes sent", expq.size(), 0);
        check_eq("R4 byte count", rx_count, 14);
        check_eq("R6 desc0 writeback", mem[32'h100 >> 2], {16'd5, 16'h0123});
        check_eq("R6 desc1 writeback", mem[32'h120 >> 2], {16'd9, 16'h0ABC});
        check_eq("R6 stop desc untouched", mem[32'h140 >> 2], {16'd4, 16'h0055});
        check_eq("R6 writes", wr_cnt, 2);
        check_eq("R11 no pending reread", watch_cnt, 1);
        reg_rd(3'd4, rd); check_eq("R8 isr set", {16'd0, rd}, 32'h10);
        check_eq("R8 irq masked", {31'd0, irq}, 0);
        reg_wr(3'd5, 16'h0010);
        check_eq("R8 irq enabled", {31'd0, irq}, 1);
        reg_wr(3'd4, 16'h0010);
        check_eq("R8 irq after clear", {31'd0, irq}, 0);
        reg_rd(3'd4, rd); check_eq("R8 isr cleared", {16'd0, rd}, 0);

        // R6: wrap from last to first
        set_desc(32'h140, 16'h8055, 16'd4, 32'h280, 32'h100);
        set_desc(32'h100, 16'h8123, 16'd3, 32'h200, 32'h120);
        expect_frame(32'h280, 4);
        expect_frame(32'h200, 3);
        watch_addr = 32'h120; watch_cnt = 0;
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R6 wrap bytes", rx_count, 21);
        check_eq("R6 wrap queue empty", expq.size(), 0);
        check_eq("R6 wrap desc2 wb", {16'd0, mem[32'h140 >> 2][15:0]}, 32'h0055);
        check_eq("R6 wrap desc0 wb", {16'd0, mem[32'h100 >> 2][15:0]}, 32'h0123);
        check_eq("R6 stop at desc1", watch_cnt, 1);
        check_eq("R8 irq raised", {31'd0, irq}, 1);
        reg_wr(3'd4, 16'h0010);

        // R7: bad lengths
        set_desc(32'h120, 16'h8000, 16'd0, 32'h240, 32'h140);
        set_desc(32'h140, 16'h8001, 16'd1600, 32'h280, 32'h100);
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R7 no bytes", rx_count, 21);
        check_eq("R7 zero length wb", {16'd0, mem[32'h120 >> 2][15:0]}, 32'h4000);
        check_eq("R7 long length wb", {16'd0, mem[32'h140 >> 2][15:0]}, 32'h4001);
        reg_rd(3'd4, rd); check_eq("R7/R8 isr set", {16'd0, rd}, 32'h10);
        reg_wr(3'd4, 16'h0010);

        // R11: poll while busy
        set_desc(32'h100, 16'h8123, 16'd40, 32'h300, 32'h120);
        fill_buf(32'h300, 40, 17);
        expect_frame(32'h300, 40);
        watch_addr = 32'h120; watch_cnt = 0;
        reg_wr(3'd1, 16'h0001);
        repeat (6) @(negedge clk);
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R11 frame done", expq.size(), 0);
        check_eq("R11 non-owned reread once", watch_cnt, 2);

        // R10: abort mid-frame, rewind
        reg_wr(3'd0, 16'h0001);
        set_desc(32'h100, 16'h8123, 16'd100, 32'h300, 32'h120);
        fill_buf(32'h300, 100, 60);
        expect_frame(32'h300, 100);
        base_rx = rx_count;
        reg_wr(3'd1, 16'h0001);
        for (int g = 0; g < 2000 && rx_count < base_rx + 10; g++) @(negedge clk);
        ready_en = 1'b0;
        repeat (2) @(negedge clk);
        reg_wr(3'd0, 16'h0001);
        check_eq("R10 tx_valid low", {31'd0, tx_valid}, 0);
        check_eq("R10 mem_req low", {31'd0, mem_req}, 0);
        repeat (4) @(negedge clk);
        check_eq("R10 no writeback", {31'd0, mem[32'h100 >> 2][15]}, 1);
        expq.delete();
        ready_en = 1'b1;
        expect_frame(32'h300, 100);
        base_rx = rx_count;
        reg_wr(3'd1, 16'h0001);
        wait_quiet();
        check_eq("R10 restart from base", rx_count - base_rx, 100);
        check_eq("R10 queue empty", expq.size(), 0);
        check_eq("R10 wb after restart", {16'd0, mem[32'h100 >> 2][15:0]}, 32'h0123);

        check_eq("R9 request held until ack", hold_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule